// File: doc/BRIEF.md
# Memory Access Cacheability and SMM Routing Decoder

This block sits next to a processor bus and classifies each memory cycle as it is strobed. Boot firmware loads a small table of address ranges through a register write port; every entry carries a base, a mask and attribute bits. On each strobed access the block looks the address up in that table and produces the cache-enable answer and the write-back/write-through select. The processor combines that select with its page-level write-through bit to choose the line state.

The region from 0x000A_0000 to 0x000F_FFFF is treated as uncached unless the winning table entry explicitly allows caching there.

While the system-management indication is active, no access reaches main memory. Every access is steered into a dedicated 64 KB management window. The upper 32 KB of that window is backed by RAM, and the handler entry point is the first address of that half. Every other address seen in management mode raises an unpopulated flag. All results are registered once and appear on the clock after the strobe.

Top module: `cache_attr_decoder`

## Requirements
- R1: After reset every table entry is disabled, all outputs are low, and the first access to any address returns cache-enable low.
- R2: Results for an access strobed on one rising edge appear, with `resp_vld` high, after that edge and hold until the next edge. On a cycle that follows no strobe, `resp_vld`, `cache_en`, `wback`, `main_sel`, `smram_sel` and `smm_unpop` are all low.
- R3: An enabled entry matches when `(addr ^ base) & mask` is zero. A matching cacheable entry gives `cache_en` high, where cacheable is bit 0 of `cfg_attr`.
- R4: When several enabled entries match, the entry with the lowest index decides the attributes.
- R5: An address that matches no enabled entry gives `cache_en` low and `wback` low.
- R6: `wback` equals the winning entry's write-back bit (bit 1 of `cfg_attr`) whenever `cache_en` is high. It is low whenever `cache_en` is low.
- R7: For addresses from 0x000A_0000 to 0x000F_FFFF, `cache_en` is high only if the winning entry is cacheable and its hole-override bit (bit 2 of `cfg_attr`) is set.
- R8: An access strobed while `smm_act` is high gives `main_sel` low, `cache_en` low and `wback` low, whatever the table holds.
- R9: In management mode, an address from 0x0003_8000 to 0x0003_FFFF gives `smram_sel` high.
- R10: In management mode, any other address, including 0x0003_0000 to 0x0003_7FFF, gives `smm_unpop` high and `smram_sel` low.
- R11: An access strobed with `smm_act` low gives `main_sel` high and `smram_sel` and `smm_unpop` low. Exactly one of the three routing outputs is high for every valid result.
- R12: A write with `cfg_we` high replaces only the entry picked by `cfg_idx`. Writing an entry with `cfg_attr` bit 3 (enable) clear removes that entry from all later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 3 | Index of the entry written |
| cfg_base | input | 32 | Entry base address |
| cfg_mask | input | 32 | Entry compare mask (1 = bit compared) |
| cfg_attr | input | 4 | Entry attributes: [0] cacheable, [1] write-back, [2] hole override, [3] enable |
| ads | input | 1 | Address strobe; the access address is sampled on this edge |
| addr | input | 32 | Access address |
| smm_act | input | 1 | System-management mode active, sampled with `ads` |
| resp_vld | output | 1 | Results below belong to the access strobed on the previous edge |
| cache_en | output | 1 | Cache-enable answer for the access |
| wback | output | 1 | 1 = write-back, 0 = write-through |
| main_sel | output | 1 | Access goes to main memory |
| smram_sel | output | 1 | Access goes to management RAM |
| smm_unpop | output | 1 | Management-mode access to an unpopulated address |

## Verification
Each lookup result is due exactly one rising edge after its strobe. A table write is visible to a strobe issued one edge after the write. The bench drives inputs on falling edges and samples all six outputs on the next falling edge, halfway between the registering edge and the following one. Back-to-back strobes are checked one result per falling edge, and a strobe-free cycle follows to confirm that the outputs fall back to low.

// File: rtl/cad_pkg.sv
package cad_pkg;

    // attribute bits held per table entry
    typedef struct packed {
        logic en;
        logic hole_ok;
        logic wb;
        logic cacheable;
    } cad_attr_t;

    // registered per-access result
    typedef struct packed {
        logic vld;
        logic ken;
        logic wb;
        logic main;
        logic smram;
        logic unpop;
    } cad_resp_t;

    localparam cad_resp_t CAD_RESP_IDLE = '{default: 1'b0};

endpackage

// File: rtl/cad_range_regs.sv
module cad_range_regs
    import cad_pkg::*;
#(
    parameter int N_RANGES = 8,
    parameter int AW = 32,
    localparam int IDX_W = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [AW-1:0]                 wr_base,
    input  logic [AW-1:0]                 wr_mask,
    input  cad_attr_t                     wr_attr,
    output logic [N_RANGES-1:0][AW-1:0]   base_o,
    output logic [N_RANGES-1:0][AW-1:0]   mask_o,
    output cad_attr_t [N_RANGES-1:0]      attr_o
);

    logic [N_RANGES-1:0][AW-1:0] base_d, base_q;
    logic [N_RANGES-1:0][AW-1:0] mask_d, mask_q;
    cad_attr_t [N_RANGES-1:0]    attr_d, attr_q;

    always_comb begin
        base_d = base_q;
        mask_d = mask_q;
        attr_d = attr_q;
        if (wr_en) begin
            base_d[wr_idx] = wr_base;
            mask_d[wr_idx] = wr_mask;
            attr_d[wr_idx] = wr_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            mask_q <= '0;
            attr_q <= '0;
        end else begin
            base_q <= base_d;
            mask_q <= mask_d;
            attr_q <= attr_d;
        end
    end

    assign base_o = base_q;
    assign mask_o = mask_q;
    assign attr_o = attr_q;

endmodule

// File: rtl/cad_range_match.sv
module cad_range_match
    import cad_pkg::*;
#(
    parameter int N_RANGES = 8,
    parameter int AW = 32
) (
    input  logic [AW-1:0]                 addr,
    input  logic [N_RANGES-1:0][AW-1:0]   base_i,
    input  logic [N_RANGES-1:0][AW-1:0]   mask_i,
    input  cad_attr_t [N_RANGES-1:0]      attr_i,
    output logic                          hit,
    output cad_attr_t                     win_attr
);

    logic [N_RANGES-1:0] hit_vec;

    for (genvar g = 0; g < N_RANGES; g++) begin : g_cmp
        assign hit_vec[g] = attr_i[g].en &&
                            (((addr ^ base_i[g]) & mask_i[g]) == '0);
    end

    // scan from the top so the lowest matching index is written last
    always_comb begin
        win_attr = '0;
        for (int i = N_RANGES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                win_attr = attr_i[i];
            end
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/cad_region_decode.sv
module cad_region_decode #(
    parameter int            AW = 32,
    parameter logic [AW-1:0] HOLE_LO = 'h000A_0000,
    parameter logic [AW-1:0] HOLE_HI = 'h000F_FFFF,
    parameter logic [AW-1:0] SMM_BASE = 'h0003_0000,
    parameter int            SMM_WIN_LOG2 = 16
) (
    input  logic [AW-1:0] addr,
    output logic          in_hole,
    output logic          in_smm_ram
);

    localparam int RAM_BIT = SMM_WIN_LOG2 - 1;

    logic in_window;

    assign in_hole    = (addr >= HOLE_LO) && (addr <= HOLE_HI);
    assign in_window  = addr[AW-1:SMM_WIN_LOG2] == SMM_BASE[AW-1:SMM_WIN_LOG2];
    assign in_smm_ram = in_window && addr[RAM_BIT];

endmodule

// File: rtl/cache_attr_decoder.sv
module cache_attr_decoder
    import cad_pkg::*;
#(
    parameter int            N_RANGES = 8,
    parameter int            AW = 32,
    parameter logic [AW-1:0] HOLE_LO = 'h000A_0000,
    parameter logic [AW-1:0] HOLE_HI = 'h000F_FFFF,
    parameter logic [AW-1:0] SMM_BASE = 'h0003_0000,
    parameter int            SMM_WIN_LOG2 = 16,
    localparam int           IDX_W = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [AW-1:0]    cfg_base,
    input  logic [AW-1:0]    cfg_mask,
    input  logic [3:0]       cfg_attr,
    input  logic             ads,
    input  logic [AW-1:0]    addr,
    input  logic             smm_act,
    output logic             resp_vld,
    output logic             cache_en,
    output logic             wback,
    output logic             main_sel,
    output logic             smram_sel,
    output logic             smm_unpop
);

    logic [N_RANGES-1:0][AW-1:0] tbl_base;
    logic [N_RANGES-1:0][AW-1:0] tbl_mask;
    cad_attr_t [N_RANGES-1:0]    tbl_attr;
    cad_attr_t                   wr_attr;
    cad_attr_t                   win_attr;
    logic                        hit;
    logic                        in_hole;
    logic                        in_smm_ram;
    cad_resp_t                   resp_d, resp_q;

    assign wr_attr = cad_attr_t'(cfg_attr);

    cad_range_regs #(.N_RANGES(N_RANGES), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_base (cfg_base),
        .wr_mask (cfg_mask),
        .wr_attr (wr_attr),
        .base_o  (tbl_base),
        .mask_o  (tbl_mask),
        .attr_o  (tbl_attr)
    );

    cad_range_match #(.N_RANGES(N_RANGES), .AW(AW)) u_match (
        .addr     (addr),
        .base_i   (tbl_base),
        .mask_i   (tbl_mask),
        .attr_i   (tbl_attr),
        .hit      (hit),
        .win_attr (win_attr)
    );

    cad_region_decode #(
        .AW           (AW),
        .HOLE_LO      (HOLE_LO),
        .HOLE_HI      (HOLE_HI),
        .SMM_BASE     (SMM_BASE),
        .SMM_WIN_LOG2 (SMM_WIN_LOG2)
    ) u_region (
        .addr       (addr),
        .in_hole    (in_hole),
        .in_smm_ram (in_smm_ram)
    );

    always_comb begin
        resp_d = CAD_RESP_IDLE;
        if (ads) begin
            resp_d.vld = 1'b1;
            if (smm_act) begin
                resp_d.smram = in_smm_ram;
                resp_d.unpop = !in_smm_ram;
            end else begin
                resp_d.main = 1'b1;
                resp_d.ken  = hit && win_attr.cacheable &&
                              (!in_hole || win_attr.hole_ok);
                resp_d.wb   = resp_d.ken && win_attr.wb;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q <= CAD_RESP_IDLE;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign resp_vld  = resp_q.vld;
    assign cache_en  = resp_q.ken;
    assign wback     = resp_q.wb;
    assign main_sel  = resp_q.main;
    assign smram_sel = resp_q.smram;
    assign smm_unpop = resp_q.unpop;

endmodule

// File: rtl/cad_checks.sv
module cad_checks #(
    parameter int            AW = 32,
    parameter logic [AW-1:0] SMM_BASE = 'h0003_0000,
    parameter int            SMM_WIN_LOG2 = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ads,
    input logic [AW-1:0] addr,
    input logic          smm_act,
    input logic          resp_vld,
    input logic          cache_en,
    input logic          wback,
    input logic          main_sel,
    input logic          smram_sel,
    input logic          smm_unpop
);

    logic smm_ram_addr;
    assign smm_ram_addr = (addr[AW-1:SMM_WIN_LOG2] == SMM_BASE[AW-1:SMM_WIN_LOG2]) &&
                          addr[SMM_WIN_LOG2-1];

    // R2
    strobe_to_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ads |=> resp_vld);

    // R2
    no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads |=> !(resp_vld || cache_en || wback || main_sel || smram_sel || smm_unpop));

    // R11
    route_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_vld |-> ($countones({main_sel, smram_sel, smm_unpop}) == 1));

    // R8
    smm_no_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads && smm_act) |=> (!main_sel && !cache_en && !wback));

    // R6
    wb_needs_ken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wback |-> cache_en);

    // R9
    smram_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads && smm_act && smm_ram_addr) |=> smram_sel);

    // R10
    smm_unpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ads && smm_act && !smm_ram_addr) |=> (smm_unpop && !smram_sel));

endmodule

bind cache_attr_decoder cad_checks #(
    .AW           (AW),
    .SMM_BASE     (SMM_BASE),
    .SMM_WIN_LOG2 (SMM_WIN_LOG2)
) u_cad_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .ads       (ads),
    .addr      (addr),
    .smm_act   (smm_act),
    .resp_vld  (resp_vld),
    .cache_en  (cache_en),
    .wback     (wback),
    .main_sel  (main_sel),
    .smram_sel (smram_sel),
    .smm_unpop (smm_unpop)
);

// File: tb/cache_attr_decoder_bench.sv
`timescale 1ns/1ps
module cache_attr_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_base = '0;
    logic [31:0] cfg_mask = '0;
    logic [3:0]  cfg_attr = '0;
    logic        ads = 1'b0;
    logic [31:0] addr = '0;
    logic        smm_act = 1'b0;
    logic        resp_vld, cache_en, wback, main_sel, smram_sel, smm_unpop;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // attribute encodings: [3] enable, [2] hole override, [1] write-back, [0] cacheable
    localparam logic [3:0] A_OFF  = 4'b0000;
    localparam logic [3:0] A_UC   = 4'b1000;
    localparam logic [3:0] A_WT   = 4'b1001;
    localparam logic [3:0] A_WB   = 4'b1011;
    localparam logic [3:0] A_WBHO = 4'b1111;

    always #2 clk = ~clk;

    cache_attr_decoder u_cache_attr_decoder (
        .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_base, .cfg_mask, .cfg_attr,
        .ads, .addr, .smm_act, .resp_vld, .cache_en, .wback,
        .main_sel, .smram_sel, .smm_unpop
    );

    // expected vector order: {vld, ken, wb, main, smram, unpop}
    function automatic logic [5:0] got_vec();
        return {resp_vld, cache_en, wback, main_sel, smram_sel, smm_unpop};
    endfunction

    task automatic check(input string req, input logic [5:0] exp);
        n_chk++;
        if (got_vec() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got_vec(), exp);
        end
    endtask

    task automatic wr_entry(input logic [2:0] idx, input logic [31:0] b,
                            input logic [31:0] m, input logic [3:0] a);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_base = b; cfg_mask = m; cfg_attr = a;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input string req, input logic [31:0] a,
                          input logic smm, input logic [5:0] exp);
        @(negedge clk);
        ads = 1'b1; addr = a; smm_act = smm;
        @(negedge clk);
        ads = 1'b0; smm_act = 1'b0;
        check(req, exp);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", 6'b000000);
        access("R1 first access uncached", 32'h0000_1000, 1'b0, 6'b100100);
        access("R11 main routing", 32'h0400_0000, 1'b0, 6'b100100);
    endtask

    task automatic t_match();
        wr_entry(3'd2, 32'h0010_0000, 32'hFFF0_0000, A_WB);
        access("R3 cacheable match", 32'h0012_3456, 1'b0, 6'b111100);
        access("R6 write-back passes", 32'h001F_FFFF, 1'b0, 6'b111100);
        access("R5 no match", 32'h0020_0000, 1'b0, 6'b100100);
    endtask

    task automatic t_priority();
        wr_entry(3'd0, 32'h0010_0000, 32'hFFFF_0000, A_UC);
        wr_entry(3'd1, 32'h0000_0000, 32'hFFC0_0000, A_WT);
        access("R4 lowest index uncached wins", 32'h0010_8000, 1'b0, 6'b100100);
        access("R4 index1 over index2", 32'h0011_0000, 1'b0, 6'b110100);
        access("R6 write-through entry", 32'h0000_1000, 1'b0, 6'b110100);
    endtask

    task automatic t_hole();
        access("R7 hole blocks plain entry", 32'h000B_8000, 1'b0, 6'b100100);
        wr_entry(3'd1, 32'h0000_0000, 32'hFFC0_0000, A_OFF);
        access("R12 disabled entry gone", 32'h0000_1000, 1'b0, 6'b100100);
        wr_entry(3'd3, 32'h000C_0000, 32'hFFFF_0000, A_WBHO);
        wr_entry(3'd5, 32'h000D_0000, 32'hFFFF_0000, A_WB);
        access("R7 override caches hole", 32'h000C_1234, 1'b0, 6'b111100);
        access("R7 no override in hole", 32'h000D_0000, 1'b0, 6'b100100);
        access("R12 other entries kept", 32'h0012_0000, 1'b0, 6'b111100);
    endtask

    task automatic t_smm();
        wr_entry(3'd1, 32'h0000_0000, 32'hFFC0_0000, A_WB);
        access("R9 handler entry", 32'h0003_8000, 1'b1, 6'b100010);
        access("R9 window top", 32'h0003_FFFF, 1'b1, 6'b100010);
        access("R10 lower half", 32'h0003_7FFF, 1'b1, 6'b100001);
        access("R10 window base", 32'h0003_0000, 1'b1, 6'b100001);
        access("R8 cacheable addr in smm", 32'h0012_0000, 1'b1, 6'b100001);
        access("R11 smm off same addr", 32'h0003_8000, 1'b0, 6'b111100);
    endtask

    task automatic t_strobe();
        @(negedge clk);
        ads = 1'b1; addr = 32'h0000_2000; smm_act = 1'b0;
        @(negedge clk);
        check("R2 first of pair", 6'b111100);
        addr = 32'h0003_9000; smm_act = 1'b1;
        @(negedge clk);
        check("R2 second of pair", 6'b100010);
        ads = 1'b0; smm_act = 1'b0;
        @(negedge clk);
        check("R2 idle after strobe", 6'b000000);
        @(negedge clk);
        check("R2 idle holds", 6'b000000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_match();
        t_priority();
        t_hole();
        t_smm();
        t_strobe();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule